// File: doc/BRIEF.md
# Nine-Bit Command/Data Serial Master

This block is a three-wire serial master that sends register commands to a display controller. Each word on the wire is nine bits wide. The top bit tells the receiver whether the word is a command (0) or a data byte (1), and the lower eight bits carry the register address or the data byte. The host logic supplies up to three ready-made words and a word count. A transaction is then one of three kinds: a lone command, a command followed by one data byte, or a command followed by a 16-bit value that the host has split high byte first.

The block drives an active-low chip select, a serial clock and a data output. It reads a data input that carries the data output looped back through the link. Every bit is compared against that echo at the end of its low clock half. A mismatch means the link is broken, and the transfer stops. The echo input passes through a two-flop synchronizer before it is used. Each clock half-period is a cycle-count parameter. The default gives 200 µs at a 250 MHz system clock, which keeps every half-period above the 150 µs minimum. The host side is a start pulse plus busy, a one-cycle done pulse and an error flag.

Top module: `ninebit_serial_master`

## Requirements
- R1: Word entry 0 of `words_i` (bits 8:0) is sent first, then entry 1 (bits 17:9), then entry 2 (bits 26:18). Each word goes out exactly as supplied: bit 8 is the command(0)/data(1) flag and bits 7:0 are the payload.
- R2: A start with `nwords_i` of 1, 2 or 3 sends exactly 9, 18 or 27 bits. A start with `nwords_i` of 0 is ignored: busy stays low and chip select stays high.
- R3: Within a word, bits go out most significant first (bit 8 first, bit 0 last).
- R4: Chip select goes low in the same cycle as the first clock fall. It stays low across all words, rises the cycle after the last bit's high half ends, and is high whenever done pulses.
- R5: Each bit drives clock low with the data bit set for HALF_CYCLES cycles, then clock high for HALF_CYCLES cycles. The data output does not change while clock is high and chip select is low.
- R6: At the last cycle of each low half, the synchronized echo is compared with the driven bit. On a mismatch, that bit gets no rising clock edge, chip select, clock and data return to idle on the next cycle, and the error flag is set.
- R7: After reset and whenever not busy, chip select is high, clock is high and data is low.
- R8: Done is a one-cycle pulse one cycle after the outputs return to idle, and busy falls with it. The error flag is valid at done and holds until the next accepted start, which clears it.
- R9: A start pulse while busy is ignored: the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| nwords_i | input | 2 | Number of words to send (1 to 3) |
| words_i | input | 27 | Three 9-bit words, entry 0 in the low bits |
| echo_i | input | 1 | Looped-back serial data, asynchronous |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out, idles low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | Echo mismatch seen in the last transfer |

## Verification
The assertions assume that `words_i` and `nwords_i` are only read in the cycle a start is accepted. They also assume that the echo is either a faithful loopback or settles at least two cycles before the end of a low half. That holds because HALF_CYCLES is held to four or more. The stimulus changes the echo source (loopback, stuck low, stuck high) only while the block is idle. It changes the word inputs only at start pulses, or during a transfer when testing that a mid-transfer start is ignored. Every output is compared, cycle by cycle, with a behavioural model fed the same inputs.

// File: rtl/ns9_pkg.sv
package ns9_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2,
      ST_FIN  = 2'd3
   } ns9_state_e;
endpackage

// File: rtl/ns9_sync.sv
module ns9_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial assert (STAGES >= 2) else $error("ns9_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else if (s == 0) chain[s] <= d_i;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ns9_half_timer.sv
module ns9_half_timer #(
   parameter int HALF_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic restart_i,
   output logic expire_o
);
   localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

   initial assert (HALF_CYCLES >= 4) else $error("ns9_half_timer: HALF_CYCLES must be at least 4");

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (restart_i) cnt <= '0;
      else if (run_i && cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign expire_o = (cnt == LAST);

   // R5: the half-period counter never passes its terminal value
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   // R5: while running, the count advances by one until restarted
   p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !restart_i && cnt != LAST) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/ns9_shifter.sv
module ns9_shifter #(
   parameter int WORD_W    = 9,
   parameter int MAX_WORDS = 3,
   parameter int NW_W      = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_i,
   input  logic                        shift_i,
   input  logic                        clear_i,
   input  logic [NW_W-1:0]             nwords_i,
   input  logic [WORD_W*MAX_WORDS-1:0] words_i,
   output logic                        bit_o,
   output logic                        last_o
);
   localparam int TOTAL = WORD_W * MAX_WORDS;
   localparam int CNT_W = $clog2(TOTAL + 1);

   logic [TOTAL-1:0] sreg, load_img;
   logic [CNT_W-1:0] left;

   // word 0 goes to the top so it leaves first, msb first
   always_comb begin
      load_img = '0;
      for (int j = 0; j < MAX_WORDS; j++)
         load_img[TOTAL-1-j*WORD_W -: WORD_W] = words_i[j*WORD_W +: WORD_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         left <= '0;
      end else if (load_i) begin
         sreg <= load_img;
         left <= CNT_W'(nwords_i) * CNT_W'(WORD_W);
      end else if (clear_i) begin
         sreg <= '0;
         left <= '0;
      end else if (shift_i) begin
         sreg <= sreg << 1;
         left <= left - 1'b1;
      end
   end

   assign bit_o  = sreg[TOTAL-1];
   assign last_o = (left == CNT_W'(1));

   // R2: a shift never consumes the final bit or runs past the word count
   p_no_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |-> left > CNT_W'(1));
endmodule

// File: rtl/ninebit_serial_master.sv
module ninebit_serial_master
   import ns9_pkg::*;
#(
   parameter int WORD_W      = 9,
   parameter int MAX_WORDS   = 3,
   parameter int HALF_CYCLES = 50000,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 start_i,
   input  logic [$clog2(MAX_WORDS+1)-1:0]       nwords_i,
   input  logic [WORD_W*MAX_WORDS-1:0]          words_i,
   input  logic                                 echo_i,
   output logic                                 cs_n_o,
   output logic                                 sclk_o,
   output logic                                 sdo_o,
   output logic                                 busy_o,
   output logic                                 done_o,
   output logic                                 err_o
);
   localparam int NW_W = $clog2(MAX_WORDS + 1);

   initial assert (HALF_CYCLES > SYNC_STAGES + 1)
      else $error("ninebit_serial_master: half-period too short for echo synchronizer");
   initial assert (MAX_WORDS >= 1 && WORD_W >= 2)
      else $error("ninebit_serial_master: bad word geometry");

   ns9_state_e st;
   logic echo_q, expire, last_bit, accept, run, mismatch;
   logic ld, shf, clr;

   ns9_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(echo_i), .q_o(echo_q));

   assign accept   = (st == ST_IDLE) && start_i &&
                     (nwords_i != '0) && (nwords_i <= NW_W'(MAX_WORDS));
   assign run      = (st == ST_LOW) || (st == ST_HIGH);
   assign mismatch = (echo_q != sdo_o);

   ns9_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_i(run),
      .restart_i(accept || (run && expire)), .expire_o(expire));

   assign ld  = accept;
   assign shf = (st == ST_HIGH) && expire && !last_bit;
   assign clr = ((st == ST_HIGH) && expire && last_bit) ||
                ((st == ST_LOW) && expire && mismatch);

   ns9_shifter #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .NW_W(NW_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(ld), .shift_i(shf), .clear_i(clr),
      .nwords_i(nwords_i), .words_i(words_i), .bit_o(sdo_o), .last_o(last_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cs_n_o <= 1'b1;
         sclk_o <= 1'b1;
         busy_o <= 1'b0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            ST_IDLE: if (accept) begin
               cs_n_o <= 1'b0;
               sclk_o <= 1'b0;
               busy_o <= 1'b1;
               err_o  <= 1'b0;
               st     <= ST_LOW;
            end
            ST_LOW: if (expire) begin
               if (mismatch) begin
                  cs_n_o <= 1'b1;
                  sclk_o <= 1'b1;
                  err_o  <= 1'b1;
                  st     <= ST_FIN;
               end else begin
                  sclk_o <= 1'b1;
                  st     <= ST_HIGH;
               end
            end
            ST_HIGH: if (expire) begin
               if (last_bit) begin
                  cs_n_o <= 1'b1;
                  st     <= ST_FIN;
               end else begin
                  sclk_o <= 1'b0;
                  st     <= ST_LOW;
               end
            end
            ST_FIN: begin
               done_o <= 1'b1;
               busy_o <= 1'b0;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R7: idle levels whenever no transfer is running
   p_idle_levels_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && sclk_o && !sdo_o));
   // R8: done lasts exactly one cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R4: chip select was already high the cycle before done
   p_done_after_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cs_n_o && $past(cs_n_o)));
   // R5: data is held while the clock is high inside a transfer
   p_sdo_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o) && !cs_n_o && !$past(cs_n_o)) |-> $stable(sdo_o));
   // R6: an echo mismatch at the end of a low half aborts to idle with error
   p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOW && expire && echo_q != sdo_o) |=> (cs_n_o && sclk_o && err_o && !sdo_o));
   // R9: a start while busy leaves the transfer state untouched
   p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && st == ST_LOW && !expire) |=> (st == ST_LOW && !cs_n_o));
endmodule

// File: tb/ninebit_serial_master_bench.sv
module ninebit_serial_master_bench;
   localparam int H = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] nwords = 2'd0;
   logic [26:0] words = '0;
   logic echo;
   logic cs_n, sclk, sdo, busy, done, err;
   int echo_mode = 0; // 0 loopback, 1 stuck low, 2 stuck high

   int checks = 0, errors = 0, cycles = 0;

   always #2 clk = ~clk;

   assign echo = (echo_mode == 0) ? sdo : (echo_mode == 2);

   ninebit_serial_master #(.HALF_CYCLES(H)) u_ninebit_serial_master (
      .clk(clk), .rst_n(rst_n), .start_i(start), .nwords_i(nwords),
      .words_i(words), .echo_i(echo), .cs_n_o(cs_n), .sclk_o(sclk),
      .sdo_o(sdo), .busy_o(busy), .done_o(done), .err_o(err));

   // behavioural reference
   int m_st = 0, m_cnt = 0, m_idx = 0, m_nb = 0;
   logic m_bits [27];
   logic m_cs = 1, m_sclk = 1, m_sdo = 0, m_busy = 0, m_done = 0, m_err = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cs = 1; m_sclk = 1; m_sdo = 0; m_busy = 0; m_done = 0; m_err = 0;
      end else begin
         m_done = 0;
         case (m_st)
            0: if (start && nwords >= 1 && nwords <= 3) begin
               m_nb = nwords * 9;
               for (int j = 0; j < m_nb; j++) m_bits[j] = words[(j/9)*9 + 8 - (j%9)];
               m_idx = 0; m_cnt = 0; m_cs = 0; m_sclk = 0; m_sdo = m_bits[0];
               m_busy = 1; m_err = 0; m_st = 1;
            end
            1: if (m_cnt == H-1) begin
               m_cnt = 0;
               if (echo_mode != 0 && m_bits[m_idx] != (echo_mode == 2)) begin
                  m_cs = 1; m_sclk = 1; m_sdo = 0; m_err = 1; m_st = 3;
               end else begin
                  m_sclk = 1; m_st = 2;
               end
            end else m_cnt++;
            2: if (m_cnt == H-1) begin
               m_cnt = 0;
               if (m_idx == m_nb-1) begin
                  m_cs = 1; m_sdo = 0; m_st = 3;
               end else begin
                  m_idx++; m_sclk = 0; m_sdo = m_bits[m_idx]; m_st = 1;
               end
            end else m_cnt++;
            default: begin m_done = 1; m_busy = 0; m_st = 0; end
         endcase
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   // per-cycle comparison and capture on rising serial clock
   logic prev_sclk = 1'b1;
   logic cap [$];
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk("R4", "cs_n", cs_n, m_cs);
         chk("R5", "sclk", sclk, m_sclk);
         chk("R3", "sdo", sdo, m_sdo);
         chk("R9", "busy", busy, m_busy);
         chk("R8", "done", done, m_done);
         chk("R6", "err", err, m_err);
         if (!prev_sclk && sclk && !cs_n) cap.push_back(sdo);
      end
      prev_sclk = sclk;
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic pulse_start(input logic [1:0] n, input logic [26:0] w);
      @(negedge clk);
      nwords = n; words = w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (done !== 1'b1 && t < 2000) begin @(negedge clk); t++; end
      if (t >= 2000) chk("R8", "done timeout", 1'b0, 1'b1);
      @(negedge clk);
   endtask

   task automatic run_tx(input string req, input logic [1:0] n, input logic [26:0] w);
      logic exp [$];
      logic exp_err = 0;
      for (int j = 0; j < n*9; j++) begin
         logic b = w[(j/9)*9 + 8 - (j%9)];
         if (echo_mode != 0 && b != (echo_mode == 2)) begin exp_err = 1; break; end
         exp.push_back(b);
      end
      cap.delete();
      pulse_start(n, w);
      wait_done();
      checks++;
      if (cap.size() != exp.size()) begin
         errors++;
         $display("FAIL %s bit count actual=%0d expected=%0d", req, cap.size(), exp.size());
      end else begin
         for (int j = 0; j < exp.size(); j++)
            chk(req, "serial bit", cap[j], exp[j]);
      end
      chk("R6", "error flag after done", err, exp_err);
      chk("R7", "idle cs_n", cs_n, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R7", "reset cs_n", cs_n, 1'b1);
      chk("R7", "reset sclk", sclk, 1'b1);
      chk("R7", "reset sdo", sdo, 1'b0);
      chk("R8", "reset busy", busy, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R3: single command word
      run_tx("R3", 2'd1, {18'h0, 9'h029});
      // R1: command plus one data byte
      run_tx("R1", 2'd2, {9'h0, 9'h180, 9'h0BC});
      // R2: command plus 16-bit value, high byte first
      run_tx("R2", 2'd3, {9'h140, 9'h120, 9'h0C3});
      run_tx("R1", 2'd3, {9'h1FF, 9'h100, 9'h0B0});

      // R2: zero word count is ignored
      pulse_start(2'd0, {9'h1AA, 9'h155, 9'h0FF});
      repeat (6) @(negedge clk);
      chk("R2", "busy after zero count", busy, 1'b0);
      chk("R2", "cs_n after zero count", cs_n, 1'b1);

      // R9: second start during a transfer is ignored
      cap.delete();
      pulse_start(2'd2, {9'h0, 9'h155, 9'h0AA});
      repeat (10) @(negedge clk);
      nwords = 2'd3; words = {9'h1FF, 9'h1FF, 9'h1FF}; start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done();
      checks++;
      if (cap.size() != 18) begin
         errors++;
         $display("FAIL R9 bit count actual=%0d expected=18", cap.size());
      end else begin
         for (int j = 0; j < 9; j++) chk("R9", "kept word0", cap[j], 1'(9'h0AA >> (8-j)));
         for (int j = 0; j < 9; j++) chk("R9", "kept word1", cap[9+j], 1'(9'h155 >> (8-j)));
      end

      // R6: stuck-low echo aborts at the first one bit
      echo_mode = 1; repeat (4) @(negedge clk);
      run_tx("R6", 2'd2, {9'h0, 9'h1FF, 9'h010});
      // R6: stuck-high echo aborts on the command flag bit
      echo_mode = 2; repeat (4) @(negedge clk);
      run_tx("R6", 2'd1, {18'h0, 9'h011});
      // R8: next clean transfer clears the error
      echo_mode = 0; repeat (4) @(negedge clk);
      run_tx("R8", 2'd3, {9'h104, 9'h108, 9'h0D0});

      repeat (5) @(negedge clk);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule